// File: doc/BRIEF.md
# Target-Ready Handshake Checker

This block is a passive monitor that sits beside a pipelined bus and watches how the target-ready line is raised and dropped. It sees the address strobe of each new transaction with two flags: whether the transaction carries write data and whether it carries an implicit writeback. It also sees the target-ready line, the data-busy line and the response strobe that retires a transaction. It drives nothing onto the bus. Any ready edge that breaks a spacing or ordering rule sets a sticky error bit for that rule and raises a one-cycle error pulse.

Transactions are kept in an in-order queue, eight deep by default. The oldest unretired transaction is the one a ready assertion serves. Its write handshake comes first and its writeback handshake second. A response strobe retires it. Every clock-count threshold is a parameter.

Top module: `ready_hs_checker`

## Requirements
- R1: A ready rising edge while the oldest queued transaction's address strobe is fewer than 3 clocks old sets err_flags[0]. Exactly 3 clocks is legal.
- R2: A ready rising edge in the same clock as a response strobe sets err_flags[1]. A ready rise one clock later is legal.
- R3: A ready rising edge sets err_flags[2] if the oldest transaction has no write or writeback handshake left, or if the queue is empty.
- R4: For a transaction with both write data and a writeback, ready must be low in the clock after the accepted write handshake. If ready is still high there, err_flags[3] is set.
- R5: Ready falling without any clock of ready high with busy low since it rose sets err_flags[4].
- R6: A ready pulse one clock wide must fall at least 3 clocks after the previous ready fall, otherwise err_flags[5] is set. Wider assertions are exempt.
- R7: An address strobe arriving while the queue holds 8 transactions and none retires that clock is dropped and sets err_flags[6].
- R8: Error bits are sticky and are cleared only by the synchronous reset. err_pulse is high for the one clock after each clock that held a violation. Both outputs are registered, so they show the violation one clock after it.
- R9: Transactions are served in strobe order. A response strobe retires the oldest one, and the next ready serves the following transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_strobe | input | 1 | Address strobe of a new transaction |
| req_wr | input | 1 | New transaction carries write data |
| req_wb | input | 1 | New transaction carries an implicit writeback |
| ready | input | 1 | Target-ready line, active high |
| busy | input | 1 | Data-busy line, active high |
| rsp_strobe | input | 1 | Response strobe retiring the oldest transaction |
| err_flags | output | 7 | Sticky per-rule error bits |
| err_pulse | output | 1 | One-clock pulse for any new violation |

## Verification
The bench puts ready exactly on the 3-clock boundary after a strobe and one clock short of it. A checker with an off-by-one age count would flag legal traffic or miss the early case. It places a ready rise in the same clock as a response and holds ready across the write-to-writeback boundary. A design that ignored the previous response, or counted the writeback as just another clock of the same assertion, would stay silent on both. It also drops ready before any accepted handshake, sends a one-clock pulse only two clocks after the previous fall, and overfills the queue by one entry. Finally it queues a write transaction ahead of an empty one, so that a queue serving the wrong entry after a response would either miss the no-transfer error or raise it too early.

// File: rtl/ready_chk_pkg.sv
package ready_chk_pkg;

  localparam int NUM_RULES    = 7;
  localparam int RULE_EARLY   = 0;
  localparam int RULE_RSPGAP  = 1;
  localparam int RULE_NOXFER  = 2;
  localparam int RULE_WBGAP   = 3;
  localparam int RULE_DROP    = 4;
  localparam int RULE_PULSE   = 5;
  localparam int RULE_OVFL    = 6;

  typedef enum logic [1:0] {
    XK_NONE  = 2'd0,
    XK_WRITE = 2'd1,
    XK_WBACK = 2'd2
  } xfer_kind_t;

  typedef struct packed {
    logic wr;
    logic wb;
  } txn_t;

endpackage

// File: rtl/rhc_txn_queue.sv
module rhc_txn_queue
  import ready_chk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int GAP   = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           push,
  input  txn_t                           push_txn,
  input  logic                           pop,
  output logic                           head_valid,
  output txn_t                           head_txn,
  output logic [$clog2(GAP+1)-1:0]       head_age,
  output logic                           overflow
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int AGE_W = $clog2(GAP + 1);

  txn_t             mem [DEPTH];
  logic [AGE_W-1:0] age [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             full, pop_ok, push_ok;

  assign full     = (count == CNT_W'(DEPTH));
  assign pop_ok   = pop && (count != '0);
  assign push_ok  = push && (!full || pop_ok);
  assign overflow = push && full && !pop_ok;

  assign head_valid = (count != '0);
  assign head_txn   = mem[rd_ptr];
  assign head_age   = age[rd_ptr];

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_txn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= next_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst) begin
        age[i] <= '0;
      end else if (push_ok && (wr_ptr == PTR_W'(i))) begin
        age[i] <= AGE_W'(1);
      end else if (age[i] != AGE_W'(GAP)) begin
        age[i] <= age[i] + AGE_W'(1);
      end
    end
  end

  // R7: occupancy never exceeds the queue depth
  p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  // R7: a dropped strobe leaves the queue full
  p_overflow_full_r7: assert property (@(posedge clk) disable iff (rst)
    overflow |=> (count == CNT_W'(DEPTH)));

endmodule

// File: rtl/rhc_ready_track.sv
module rhc_ready_track
  import ready_chk_pkg::*;
#(
  parameter int GAP       = 3,
  parameter int PULSE_GAP = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ready,
  input  logic                     busy,
  input  logic                     rsp,
  input  logic                     head_valid,
  input  txn_t                     head_txn,
  input  logic [$clog2(GAP+1)-1:0] head_age,
  output logic [5:0]               viol
);

  localparam int AGE_W = $clog2(GAP + 1);
  localparam int SF_W  = $clog2(PULSE_GAP + 1);

  logic             ready_q, rose_last, hs_seen;
  logic             wr_done, wb_done, wr_hs_last;
  xfer_kind_t       kind_q, kind_new, kind_cur;
  logic [SF_W-1:0]  since_fall;
  logic             rise, fall, pop, hs_prior, hs_first;

  assign rise     = ready && !ready_q;
  assign fall     = !ready && ready_q;
  assign pop      = rsp && head_valid;
  assign hs_prior = rise ? 1'b0 : hs_seen;
  assign hs_first = ready && !busy && !hs_prior;

  always_comb begin
    kind_new = XK_NONE;
    if (head_valid) begin
      if (head_txn.wr && !wr_done)      kind_new = XK_WRITE;
      else if (head_txn.wb && !wb_done) kind_new = XK_WBACK;
    end
    kind_cur = rise ? kind_new : kind_q;
  end

  always_comb begin
    viol = '0;
    viol[RULE_EARLY]  = rise && head_valid && (head_age < AGE_W'(GAP));
    viol[RULE_RSPGAP] = rise && rsp;
    viol[RULE_NOXFER] = rise && (kind_new == XK_NONE);
    viol[RULE_WBGAP]  = ready && ready_q && wr_hs_last;
    viol[RULE_DROP]   = fall && !hs_seen;
    viol[RULE_PULSE]  = fall && rose_last && (since_fall < SF_W'(PULSE_GAP));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q    <= 1'b0;
      rose_last  <= 1'b0;
      hs_seen    <= 1'b0;
      kind_q     <= XK_NONE;
      wr_done    <= 1'b0;
      wb_done    <= 1'b0;
      wr_hs_last <= 1'b0;
      since_fall <= SF_W'(PULSE_GAP);
    end else begin
      ready_q   <= ready;
      rose_last <= rise;
      kind_q    <= kind_cur;
      if (rise)                hs_seen <= !busy;
      else if (ready && !busy) hs_seen <= 1'b1;
      if (pop) begin
        wr_done <= 1'b0;
        wb_done <= 1'b0;
      end else if (hs_first) begin
        if (kind_cur == XK_WRITE) wr_done <= 1'b1;
        if (kind_cur == XK_WBACK) wb_done <= 1'b1;
      end
      wr_hs_last <= hs_first && (kind_cur == XK_WRITE) && head_txn.wb && !pop;
      if (fall)                                since_fall <= SF_W'(1);
      else if (since_fall != SF_W'(PULSE_GAP)) since_fall <= since_fall + SF_W'(1);
    end
  end

  // R4: the writeback handshake never completes ahead of the write one
  p_wb_after_wr_r4: assert property (@(posedge clk) disable iff (rst)
    wb_done |-> (wr_done || !head_txn.wr));

  // R9: retiring a transaction clears its handshake progress
  p_done_clear_r9: assert property (@(posedge clk) disable iff (rst)
    pop |=> (!wr_done && !wb_done));

endmodule

// File: rtl/rhc_err_collect.sv
module rhc_err_collect #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] viol,
  output logic [N-1:0] flags,
  output logic         pulse
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      pulse <= 1'b0;
    end else begin
      flags <= flags | viol;
      pulse <= |viol;
    end
  end

  // R8: a set error bit stays set until reset
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags & $past(flags)) == $past(flags)));

  // R8: a pulse is always backed by at least one flag
  p_pulse_flags_r8: assert property (@(posedge clk) disable iff (rst)
    pulse |-> (flags != '0));

endmodule

// File: rtl/ready_hs_checker.sv
module ready_hs_checker
  import ready_chk_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int GAP       = 3,
  parameter int PULSE_GAP = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_strobe,
  input  logic                 req_wr,
  input  logic                 req_wb,
  input  logic                 ready,
  input  logic                 busy,
  input  logic                 rsp_strobe,
  output logic [NUM_RULES-1:0] err_flags,
  output logic                 err_pulse
);

  localparam int AGE_W = $clog2(GAP + 1);

  txn_t                 push_txn, head_txn;
  logic                 head_valid, overflow;
  logic [AGE_W-1:0]     head_age;
  logic [5:0]           track_viol;
  logic [NUM_RULES-1:0] viol;

  assign push_txn = '{wr: req_wr, wb: req_wb};

  rhc_txn_queue #(.DEPTH(DEPTH), .GAP(GAP)) u_queue (
    .clk        (clk),
    .rst        (rst),
    .push       (req_strobe),
    .push_txn   (push_txn),
    .pop        (rsp_strobe),
    .head_valid (head_valid),
    .head_txn   (head_txn),
    .head_age   (head_age),
    .overflow   (overflow)
  );

  rhc_ready_track #(.GAP(GAP), .PULSE_GAP(PULSE_GAP)) u_track (
    .clk        (clk),
    .rst        (rst),
    .ready      (ready),
    .busy       (busy),
    .rsp        (rsp_strobe),
    .head_valid (head_valid),
    .head_txn   (head_txn),
    .head_age   (head_age),
    .viol       (track_viol)
  );

  assign viol = {overflow, track_viol};

  rhc_err_collect #(.N(NUM_RULES)) u_collect (
    .clk   (clk),
    .rst   (rst),
    .viol  (viol),
    .flags (err_flags),
    .pulse (err_pulse)
  );

endmodule

// File: tb/test_ready_hs_checker.sv
module test_ready_hs_checker;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_strobe = 1'b0, req_wr = 1'b0, req_wb = 1'b0;
  logic       ready = 1'b0, busy = 1'b0, rsp_strobe = 1'b0;
  logic [6:0] err_flags;
  logic       err_pulse;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ready_hs_checker i_ready_hs_checker (
    .clk(clk), .rst(rst), .req_strobe(req_strobe), .req_wr(req_wr),
    .req_wb(req_wb), .ready(ready), .busy(busy), .rsp_strobe(rsp_strobe),
    .err_flags(err_flags), .err_pulse(err_pulse)
  );

  task automatic step(input logic s, input logic w, input logic b,
                      input logic y, input logic k, input logic p);
    @(negedge clk);
    req_strobe = s; req_wr = w; req_wb = b;
    ready = y; busy = k; rsp_strobe = p;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic check(input string req, input logic [6:0] ef, input logic ep);
    total++;
    if (err_flags !== ef || err_pulse !== ep) begin
      bad++;
      $display("FAIL %s: flags=%b pulse=%b expected flags=%b pulse=%b",
               req, err_flags, err_pulse, ef, ep);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_strobe = 0; req_wr = 0; req_wb = 0; ready = 0; busy = 0; rsp_strobe = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R8 reset state", 7'b0, 1'b0);
  endtask

  // R1 boundary: ready exactly 3 clocks after strobe, legal traffic
  task automatic t_legal_write();
    do_reset();
    step(1, 1, 0, 0, 0, 0);
    idle(2);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    check("R1 legal write at 3 clocks", 7'b0, 1'b0);
  endtask

  task automatic t_early();
    do_reset();
    step(1, 1, 0, 0, 0, 0);
    idle(1);
    step(0, 0, 0, 1, 0, 0);
    check("R1 ready 2 clocks after strobe", 7'b0000001, 1'b1);
    step(0, 0, 0, 0, 0, 0);
    check("R8 pulse one clock, flag sticky", 7'b0000001, 1'b0);
  endtask

  task automatic t_rsp_gap();
    do_reset();
    step(1, 1, 0, 0, 0, 0);
    idle(4);
    check("R2 no error before", 7'b0, 1'b0);
    step(0, 0, 0, 1, 0, 1);
    check("R2 ready with response", 7'b0000010, 1'b1);
    step(0, 0, 0, 0, 0, 0);
    check("R2 nothing else", 7'b0000010, 1'b0);
  endtask

  task automatic t_noxfer();
    do_reset();
    step(1, 0, 0, 0, 0, 0);
    idle(2);
    step(0, 0, 0, 1, 0, 0);
    check("R3 transaction with no transfer", 7'b0000100, 1'b1);
    do_reset();
    step(0, 0, 0, 1, 0, 0);
    check("R3 ready with empty queue", 7'b0000100, 1'b1);
  endtask

  task automatic t_wb_legal();
    do_reset();
    step(1, 1, 1, 0, 0, 0);
    idle(2);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    check("R4 R6 legal write then writeback", 7'b0, 1'b0);
  endtask

  task automatic t_wb_gap();
    do_reset();
    step(1, 1, 1, 0, 0, 0);
    idle(2);
    step(0, 0, 0, 1, 0, 0);
    check("R4 before hold", 7'b0, 1'b0);
    step(0, 0, 0, 1, 0, 0);
    check("R4 ready held past write handshake", 7'b0001000, 1'b1);
    step(0, 0, 0, 0, 0, 0);
    check("R4 fall afterwards legal", 7'b0001000, 1'b0);
  endtask

  task automatic t_drop();
    do_reset();
    step(1, 1, 0, 0, 0, 0);
    idle(2);
    step(0, 0, 0, 1, 1, 0);
    check("R5 busy at assertion is fine", 7'b0, 1'b0);
    step(0, 0, 0, 0, 0, 0);
    check("R5 fall with no handshake", 7'b0010000, 1'b1);
  endtask

  task automatic t_pulse();
    do_reset();
    step(1, 1, 1, 0, 0, 0);
    idle(2);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    check("R6 before second fall", 7'b0, 1'b0);
    step(0, 0, 0, 0, 0, 0);
    check("R6 one-clock pulse 2 clocks after fall", 7'b0100000, 1'b1);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 8; i++) step(1, 1, 0, 0, 0, 0);
    check("R7 eight entries fit", 7'b0, 1'b0);
    step(1, 1, 0, 0, 0, 0);
    check("R7 ninth strobe overflows", 7'b1000000, 1'b1);
  endtask

  task automatic t_order();
    do_reset();
    step(1, 1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    idle(1);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    idle(1);
    check("R9 first transaction served legally", 7'b0, 1'b0);
    step(0, 0, 0, 1, 0, 0);
    check("R9 next ready serves empty second txn", 7'b0000100, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<20000", cycles);
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_legal_write();
    t_early();
    t_rsp_gap();
    t_noxfer();
    t_wb_legal();
    t_wb_gap();
    t_drop();
    t_pulse();
    t_overflow();
    t_order();
    finish_run();
  end

endmodule